// File: doc/BRIEF.md
# Twin Tick Timers with Buzzer Source Select

This block holds two identical 16-bit down-counters. Each one steps on a single-cycle tick that is taken from one of two slow rates, and both rates are divided down from the system clock. A timer in periodic mode refills from its programmed start value when it steps past zero. A timer in free mode rolls over to all ones. Every underflow raises a one-cycle interrupt pulse for the timer that underflowed.

A buzzer pin takes one of two sources. The first is a software bit. The second is a flop that flips on every underflow of timer 0, which gives a square wave whose period is two reload intervals.

Software sees a flat write port and one count readback. The write addresses are:
- Address 0: control.
- Address 1: start value of timer 0.
- Address 2: start value of timer 1.

Writing a start value also places that value in the counter at once.

Top module: `tmrpair_top`

## Requirements
- R1: A synchronous reset clears both counts, both start values, all control bits, the buzzer toggle flop and both interrupt pulses.
- R2: Writing address 1 (timer 0) or address 2 (timer 1) stores wrData as that timer's start value. The count shows that value from the next cycle.
- R3: With control bit 1 (timer 0) or bit 3 (timer 1) set, the timer steps once on the fast tick. The fast tick fires on every FAST_DIV-th clock after reset. A step at a nonzero count subtracts one.
- R4: With that rate bit clear, the timer steps once on the slow tick. The slow tick fires on every (FAST_DIV*SLOW_DIV)-th clock after reset.
- R5: With control bit 0 (timer 0) or bit 2 (timer 1) set, a step at count zero reloads the stored start value.
- R6: With that mode bit clear, a step at count zero sets the count to all ones.
- R7: A step at count zero makes that timer's irq bit high for exactly the following cycle (irq[0] is timer 0, irq[1] is timer 1).
- R8: With control bit 5 clear, the buzzer pin equals control bit 4.
- R9: With control bit 5 set, the buzzer pin shows a flop that inverts on every timer-0 underflow.
- R10: The two timers keep separate counts, start values and settings. Activity on one does not change the other.
- R11: A start-value write in the same cycle as a step wins: the count takes the written value and no underflow is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 control, 1 timer 0 start, 2 timer 1 start |
| wrData | input | 16 | Write data |
| rdSel | input | 1 | Selects which timer count appears on rdData |
| rdData | output | 16 | Current count of the selected timer |
| irq | output | 2 | Per-timer one-cycle underflow pulses |
| buzzer | output | 1 | Buzzer drive pin |

## Verification
The timers are run in four combinations: periodic with the fast rate, free with the fast rate, and each mode with the slow rate. These combinations separate the reload paths from the wrap paths and the fast tick from the slow tick. Small start values, including zero, force frequent underflows. They show whether reload, the interrupt pulse and the buzzer toggle happen on the step at zero and not one step early or late.

One start-value write is timed to land on a fast-tick edge, which tells load priority apart from a step. The buzzer is driven first from the software bit and then from the timer-0 toggle. Together these cover both sources and the switch between them.

// File: rtl/tmrpair_pkg.sv
package tmrpair_pkg;
  typedef struct packed {
    logic [1:0] load;      // per-timer start-value write
    logic [1:0] step;      // per-timer count enable for this cycle
    logic [1:0] periodic;  // per-timer reload select
    logic       buzzSw;    // software buzzer level
    logic       buzzMode;  // 1: timer-0 toggle drives buzzer
  } tmrStrobe_t;
endpackage

// File: rtl/tmrpair_ctrl.sv
module tmrpair_ctrl
  import tmrpair_pkg::*;
#(
  parameter int FAST_DIV = 64,
  parameter int SLOW_DIV = 256,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output tmrStrobe_t        strb
);
  localparam int FW = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
  localparam int SW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int CTRL_W = 6;

  logic [FW-1:0]     fastCnt;
  logic [SW-1:0]     slowCnt;
  logic              fastTick;
  logic              slowTick;
  logic [CTRL_W-1:0] ctrlReg;

  assign fastTick = (fastCnt == FW'(FAST_DIV - 1));
  assign slowTick = fastTick && (slowCnt == SW'(SLOW_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      fastCnt <= '0;
      slowCnt <= '0;
    end else begin
      fastCnt <= fastTick ? '0 : fastCnt + 1'b1;
      if (fastTick)
        slowCnt <= slowTick ? '0 : slowCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      ctrlReg <= '0;
    else if (wrEn && wrAddr == 2'd0)
      ctrlReg <= wrData[CTRL_W-1:0];
  end

  for (genvar i = 0; i < 2; i++) begin : g_tmr
    assign strb.periodic[i] = ctrlReg[2*i];
    assign strb.step[i]     = ctrlReg[2*i+1] ? fastTick : slowTick;
    assign strb.load[i]     = wrEn && (wrAddr == 2'(i + 1));
  end

  assign strb.buzzSw   = ctrlReg[4];
  assign strb.buzzMode = ctrlReg[5];
endmodule

// File: rtl/tmrpair_dp.sv
module tmrpair_dp
  import tmrpair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  tmrStrobe_t            strb,
  input  logic [CNT_W-1:0]      wrData,
  output logic [1:0][CNT_W-1:0] cnt,
  output logic [1:0]            irq,
  output logic                  buzzer
);
  logic [CNT_W-1:0] cntQ   [2];
  logic [CNT_W-1:0] startQ [2];
  logic             irqQ   [2];
  logic [1:0]       under;
  logic             buzzTog;

  for (genvar i = 0; i < 2; i++) begin : g_ctr
    assign under[i] = strb.step[i] && !strb.load[i] && (cntQ[i] == '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        cntQ[i]   <= '0;
        startQ[i] <= '0;
        irqQ[i]   <= 1'b0;
      end else begin
        irqQ[i] <= under[i];
        if (strb.load[i]) begin
          cntQ[i]   <= wrData;
          startQ[i] <= wrData;
        end else if (under[i]) begin
          cntQ[i] <= strb.periodic[i] ? startQ[i] : '1;
        end else if (strb.step[i]) begin
          cntQ[i] <= cntQ[i] - 1'b1;
        end
      end
    end

    assign cnt[i] = cntQ[i];
    assign irq[i] = irqQ[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      buzzTog <= 1'b0;
    else if (under[0])
      buzzTog <= ~buzzTog;
  end

  assign buzzer = strb.buzzMode ? buzzTog : strb.buzzSw;
endmodule

// File: rtl/tmrpair_top.sv
module tmrpair_top
  import tmrpair_pkg::*;
#(
  parameter int FAST_DIV = 64,
  parameter int SLOW_DIV = 256,
  parameter int CNT_W    = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             rdSel,
  output logic [CNT_W-1:0] rdData,
  output logic [1:0]       irq,
  output logic             buzzer
);
  tmrStrobe_t            strb;
  logic [1:0][CNT_W-1:0] cnt;

  tmrpair_ctrl #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .DATA_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strb(strb)
  );

  tmrpair_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .wrData(wrData),
    .cnt(cnt), .irq(irq), .buzzer(buzzer)
  );

  assign rdData = cnt[rdSel];
endmodule

// File: rtl/tmrpair_chk.sv
module tmrpair_chk
  import tmrpair_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                  clk,
  input logic                  rst,
  input tmrStrobe_t            strb,
  input logic [1:0][CNT_W-1:0] cnt,
  input logic [CNT_W-1:0]      wrData,
  input logic [1:0]            irq,
  input logic                  buzzer
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (cnt[0] == '0 && cnt[1] == '0 && irq == 2'b00 && buzzer == 1'b0));

  for (genvar i = 0; i < 2; i++) begin : g_a
    a_r2_load_now: assert property (@(posedge clk) disable iff (rst)
      strb.load[i] |=> cnt[i] == $past(wrData));

    a_r3_step_dec: assert property (@(posedge clk) disable iff (rst)
      (strb.step[i] && !strb.load[i] && cnt[i] != '0) |=> cnt[i] == $past(cnt[i]) - CNT_W'(1));

    a_r6_free_wrap: assert property (@(posedge clk) disable iff (rst)
      (strb.step[i] && !strb.load[i] && cnt[i] == '0 && !strb.periodic[i]) |=> cnt[i] == '1);

    a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
      irq[i] |-> $past(strb.step[i] && !strb.load[i] && cnt[i] == '0));
  end

  a_r9_toggle_src: assert property (@(posedge clk) disable iff (rst)
    (strb.buzzMode && $past(strb.buzzMode) && buzzer != $past(buzzer)) |-> irq[0]);
endmodule

bind tmrpair_top tmrpair_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .strb(strb), .cnt(cnt), .wrData(wrData), .irq(irq), .buzzer(buzzer)
);

// File: tb/test_tmrpair_top.sv
module test_tmrpair_top;
  localparam int FD = 4;
  localparam int SD = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic        rdSel = 1'b0;
  logic [15:0] rdData;
  logic [1:0]  irq;
  logic        buzzer;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string curReq = "R1";

  // reference state
  int mCnt [2];
  int mStart [2];
  int mPer [2];
  int mFast [2];
  int mIrq [2];
  int mSw, mMode, mTog;
  int k;

  always #2.5 clk = ~clk;

  tmrpair_top #(.FAST_DIV(FD), .SLOW_DIV(SD), .CNT_W(16)) i_tmrpair_top (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdSel(rdSel), .rdData(rdData), .irq(irq), .buzzer(buzzer)
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 2; i++) begin
        mCnt[i] = 0; mStart[i] = 0; mPer[i] = 0; mFast[i] = 0; mIrq[i] = 0;
      end
      mSw = 0; mMode = 0; mTog = 0; k = 0;
    end else begin
      bit ft, st;
      ft = (k % FD) == FD - 1;
      st = (k % (FD * SD)) == FD * SD - 1;
      for (int i = 0; i < 2; i++) begin
        bit stp, ld;
        stp = (mFast[i] != 0) ? ft : st;
        ld  = wrEn && (wrAddr == 2'(i + 1));
        mIrq[i] = 0;
        if (ld) begin
          mCnt[i] = wrData; mStart[i] = wrData;
        end else if (stp) begin
          if (mCnt[i] == 0) begin
            mIrq[i] = 1;
            mCnt[i] = (mPer[i] != 0) ? mStart[i] : 65535;
            if (i == 0) mTog = 1 - mTog;
          end else mCnt[i] = mCnt[i] - 1;
        end
      end
      if (wrEn && wrAddr == 2'd0) begin
        mPer[0] = wrData[0]; mFast[0] = wrData[1];
        mPer[1] = wrData[2]; mFast[1] = wrData[3];
        mSw = wrData[4]; mMode = wrData[5];
      end
      k = k + 1;
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(curReq, rdData, mCnt[rdSel], "count");
      chk(curReq, irq[0], mIrq[0], "irq0");
      chk(curReq, irq[1], mIrq[1], "irq1");
      chk(curReq, buzzer, (mMode != 0) ? mTog : mSw, "buzzer");
    end
  end

  always begin
    repeat (3) @(negedge clk);
    rdSel = ~rdSel;
  end

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'(a); wrData = 16'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    // R1: outputs must be clear right after reset
    chk("R1", rdData, 0, "reset count");
    chk("R1", buzzer, 0, "reset buzzer");
    @(negedge clk) rst = 1'b0;
    curReq = "R2,R4,R10";
    wr(1, 5);
    wr(2, 3);
    idle(40);
    curReq = "R3,R5,R6,R7,R10";
    wr(0, 6'b00_0011);   // t0 periodic fast, t1 free slow
    idle(60);
    wr(0, 6'b00_1011);   // t1 free fast
    idle(40);
    wr(2, 0);
    idle(30);
    curReq = "R5,R4";
    wr(0, 6'b00_0100);   // t1 periodic slow, t0 free slow
    wr(2, 1);
    wr(1, 0);
    idle(100);
    curReq = "R11";
    wr(0, 6'b00_1111);
    while ((k % FD) != FD - 1) @(negedge clk);
    wrEn = 1'b1; wrAddr = 2'd1; wrData = 16'd0;
    @(negedge clk) wrEn = 1'b0;
    idle(2);
    curReq = "R8";
    wr(0, 6'b01_1111);
    idle(10);
    wr(0, 6'b00_1111);
    idle(10);
    curReq = "R9";
    wr(1, 2);
    wr(0, 6'b10_1111);
    idle(80);
    wr(0, 6'b11_1111);
    idle(20);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule